// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one 16-bit capture/compare channel of a general-purpose timer. It comes with a simple up-counter model. One holding register changes its role with the timer mode. In compare use, the register feeds a shadow buffer. The running count is checked against that buffer, and each match raises a one-cycle interrupt pulse and can toggle an output pin. In capture use, a valid edge on a synchronised trigger pin stores the running count in the register. In width-measurement mode, the same edge also asks the counter to restart from zero.

Software reaches the register through a single-cycle read/write port. This port carries register accesses, not a data stream, so it has no valid/ready pair and applies no back-pressure. A write strobe is always taken in the cycle it is presented. A read strobe always loads the read-data output at the next clock edge, and the output then holds until the next read strobe. The trigger, the mode inputs and the status outputs are plain level or pulse signals.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset, the count, the read-data output, the match pulse and the toggle pin are all zero, and the holding register and the shadow buffer hold 0000h.
- R2: A write strobe stores all 16 bits of the write data in the holding register. A read strobe returns the register contents on the read-data output from the next cycle, and that output holds until the next read.
- R3: The channel is in capture use when the mode code is 1 (width measurement), or when the mode code is 0 (free-running) and the capture select is 1. Every other combination is compare use, and in compare use trigger edges never change the register.
- R4: While the counter is stopped, the shadow buffer copies the holding register on every clock. While the counter runs, a write loads the shadow buffer with the written value at the same edge as the register.
- R5: In compare use, with the counter running and the count equal to the shadow buffer, the match output is high for exactly the following cycle.
- R6: The toggle pin inverts at the edge that raises the match pulse, but only if the output enable was high in the matching cycle. Otherwise it holds.
- R7: The edge-select code is 0 for no edge, 1 for rising, 2 for falling and 3 for both. The trigger passes two flip-flops first, so a level change first sampled at clock edge k causes a capture at edge k+2.
- R8: In capture use with the counter running, a valid edge stores the count of the capturing cycle in the register.
- R9: In width-measurement mode, a capture drives the clear-request output high in the capturing cycle, and the count is zero in the next cycle.
- R10: A read strobe in the same cycle as a capture returns the value the register held before the capture. The captured value appears on the next read.
- R11: A capture takes priority over a write in the same cycle. The register gets the count, not the write data.
- R12: The counter adds one per clock while enabled and wraps from FFFFh to 0000h. While disabled it is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter run enable |
| mode | input | 2 | Timer mode: 0 free-running, 1 width measurement, 2 and 3 compare-only modes |
| cap_sel | input | 1 | In free-running mode, 1 selects capture use |
| edge_sel | input | 2 | Valid trigger edge: 0 none, 1 rising, 2 falling, 3 both |
| trig_in | input | 1 | Asynchronous capture trigger |
| out_en | input | 1 | Toggle-pin enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 16 | Read data, loaded on a read strobe |
| count | output | 16 | Current counter value |
| cnt_clear | output | 1 | Counter clear request from a width-measurement capture |
| match_irq | output | 1 | One-cycle compare-match interrupt pulse |
| tout | output | 1 | Toggle output pin |

## Verification
Two collisions matter. A capture can land in the same cycle as a register read, and it can land in the same cycle as a register write. The bench sets the trigger level and then raises the read or write strobe on the second falling edge after it. With two synchroniser stages, this places the strobe exactly in the capturing cycle. A collided read must return the register value read just before the trigger, and only the following read may show the new count. A collided write must leave the captured count in place of the written data. A reference model checks every other cycle around these events.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int unsigned TCC_W = 16;

  typedef enum logic [1:0] {
    TM_FREE     = 2'd0,
    TM_WIDTH    = 2'd1,
    TM_INTERVAL = 2'd2,
    TM_OTHER    = 2'd3
  } tcc_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } tcc_edge_e;
endpackage

// File: rtl/tcc_edge_det.sv
module tcc_edge_det
  import tcc_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trig,
  input  tcc_edge_e sel,
  output logic      hit
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] chain;
  logic          rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= trig;
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign rise = chain[LAST-1] & ~chain[LAST];
  assign fall = ~chain[LAST-1] & chain[LAST];

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (!en) count <= '0;
    else if (clr) count <= '0;
    else          count <= count + 1'b1;
  end

  // R12
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (count == W'($past(count) + 1'b1)));

  // R9
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/tcc_ccr.sv
module tcc_ccr #(
  parameter int unsigned W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cap_use,
  input  logic         cap_evt,
  input  logic [W-1:0] count_in,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         match
);
  logic [W-1:0] hold_q;
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= RST_VAL;
      shadow_q <= RST_VAL;
      rd_data  <= '0;
    end else begin
      if (cap_evt)    hold_q <= count_in;
      else if (wr_en) hold_q <= wr_data;

      if (!run)       shadow_q <= hold_q;
      else if (wr_en) shadow_q <= wr_data;

      if (rd_en)      rd_data <= hold_q;
    end
  end

  assign match = !cap_use && run && (count_in == shadow_q);

  // R8
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (hold_q == $past(count_in)));

  // R4
  shadow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en) |=> (shadow_q == $past(wr_data)));

  // R10
  rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data == $past(hold_q)));
endmodule

// File: rtl/tcc_out.sv
module tcc_out (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic out_en,
  output logic irq,
  output logic tout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      tout <= 1'b0;
    end else begin
      irq <= hit;
      if (hit && out_en) tout <= ~tout;
    end
  end

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6
  tout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tout) |-> irq);

  // R6
  tout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(out_en)) |-> $stable(tout));
endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
  import tcc_pkg::*;
#(
  parameter int unsigned W           = TCC_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [1:0]   mode,
  input  logic         cap_sel,
  input  logic [1:0]   edge_sel,
  input  logic         trig_in,
  input  logic         out_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] count,
  output logic         cnt_clear,
  output logic         match_irq,
  output logic         tout
);
  tcc_mode_e mode_e;
  logic      edge_hit, cap_use, cap_evt, match;

  assign mode_e    = tcc_mode_e'(mode);
  assign cap_use   = (mode_e == TM_WIDTH) || ((mode_e == TM_FREE) && cap_sel);
  assign cap_evt   = cap_use && edge_hit && cnt_en;
  assign cnt_clear = cap_evt && (mode_e == TM_WIDTH);

  tcc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (trig_in),
    .sel  (tcc_edge_e'(edge_sel)),
    .hit  (edge_hit)
  );

  tcc_counter #(.W(W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cnt_en),
    .clr  (cnt_clear),
    .count(count)
  );

  tcc_ccr #(.W(W)) u_ccr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cnt_en),
    .cap_use (cap_use),
    .cap_evt (cap_evt),
    .count_in(count),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .match   (match)
  );

  tcc_out u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (match),
    .out_en(out_en),
    .irq   (match_irq),
    .tout  (tout)
  );

  // R3
  cmp_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == TM_INTERVAL || mode_e == TM_OTHER) |-> !cnt_clear);
endmodule

// File: tb/test_tmr_cc_channel.sv
module test_tmr_cc_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic        cap_sel = 1'b0;
  logic [1:0]  edge_sel = 2'd0;
  logic        trig_in = 1'b0;
  logic        out_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data, count;
  logic        cnt_clear, match_irq, tout;

  int n_vec = 0;
  int n_bad = 0;
  int irq_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_cc_channel i_tmr_cc_channel (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .cap_sel(cap_sel),
    .edge_sel(edge_sel), .trig_in(trig_in), .out_en(out_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .count(count),
    .cnt_clear(cnt_clear), .match_irq(match_irq), .tout(tout)
  );

  // behavioural reference
  bit [15:0] m_cnt, m_reg, m_shadow, m_rd;
  bit        m_irq, m_tout;
  bit        m_hist[$];

  function automatic bit m_capuse();
    return (mode == 2'd1) || (mode == 2'd0 && cap_sel);
  endfunction

  function automatic bit m_capture();
    bit now_lv, old_lv, hit;
    now_lv = m_hist[1];
    old_lv = m_hist[2];
    case (edge_sel)
      2'd1: hit = now_lv && !old_lv;
      2'd2: hit = !now_lv && old_lv;
      2'd3: hit = now_lv != old_lv;
      default: hit = 0;
    endcase
    return m_capuse() && hit && cnt_en;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_reg = 0; m_shadow = 0; m_rd = 0; m_irq = 0; m_tout = 0;
      m_hist = '{0, 0, 0};
    end else begin
      bit cap, clr, mh;
      bit [15:0] old_reg;
      cap = m_capture();
      clr = cap && mode == 2'd1;
      mh  = !m_capuse() && cnt_en && (m_cnt == m_shadow);
      old_reg = m_reg;
      if (cap) m_reg = m_cnt; else if (wr_en) m_reg = wr_data;
      if (!cnt_en) m_shadow = old_reg; else if (wr_en) m_shadow = wr_data;
      if (rd_en) m_rd = old_reg;
      m_cnt = !cnt_en ? 16'd0 : clr ? 16'd0 : m_cnt + 16'd1;
      m_irq = mh;
      if (mh && out_en) m_tout = !m_tout;
      m_hist.push_front(trig_in);
      void'(m_hist.pop_back());
    end
    #5;
    if (rst_n && !done) begin
      check("R12 count", count, m_cnt);
      check("R9 cnt_clear", cnt_clear, m_capture() && mode == 2'd1);
      check("R5 match_irq", match_irq, m_irq);
      check("R6 tout", tout, m_tout);
      check("R2 rd_data", rd_data, m_rd);
      if (match_irq) irq_seen++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [15:0] v);
    wr_en = 1; wr_data = v; tick(1); wr_en = 0;
  endtask

  task automatic do_read();
    rd_en = 1; tick(1); rd_en = 0;
  endtask

  initial begin
    logic [15:0] prev;
    tick(3);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 tout", tout, 0);
    check("R1 match_irq", match_irq, 0);
    rst_n = 1; tick(2);
    do_read();
    check("R1 register", rd_data, 0);

    // R2 write/read while stopped, compare use
    do_write(16'h0005); tick(1);
    do_read();
    check("R2 readback", rd_data, 16'h0005);

    // R5 R6 compare match with pin enabled
    out_en = 1; cnt_en = 1; irq_seen = 0; tick(12);
    check("R5 one match", irq_seen, 1);
    check("R6 pin toggled", tout, 1);

    // R4 write while running loads buffer at once
    out_en = 0; do_write(16'd40); irq_seen = 0; tick(40);
    check("R4 running write match", irq_seen, 1);
    check("R6 pin held", tout, 1);

    // R3 interval mode ignores trigger edges
    edge_sel = 2'd3; trig_in = 1; tick(4); trig_in = 0; tick(4);
    do_read();
    check("R3 no capture", rd_data, 16'd40);
    // R3 free-running with select low is still compare
    mode = 2'd0; cap_sel = 0; trig_in = 1; tick(4); trig_in = 0; tick(4);
    do_read();
    check("R3 free compare", rd_data, 16'd40);

    // R8 R7 free capture, rising edge
    cap_sel = 1; edge_sel = 2'd1; tick(2);
    trig_in = 1; tick(5);
    do_read();
    check("R8 rise capture", rd_data, m_rd);
    check("R7 rise captured", rd_data != 16'd40, 1);
    // R7 falling edge
    edge_sel = 2'd2; tick(3); trig_in = 0; tick(5);
    do_read(); check("R7 fall capture", rd_data, m_rd);
    // R7 no edge selected: register unchanged
    prev = rd_data; edge_sel = 2'd0;
    trig_in = 1; tick(4); trig_in = 0; tick(4);
    do_read(); check("R7 none", rd_data, prev);

    // R10 read collides with capture
    edge_sel = 2'd3; tick(2);
    trig_in = 1; tick(2); rd_en = 1; tick(1); rd_en = 0;
    check("R10 old value", rd_data, prev);
    tick(1); do_read();
    check("R10 new value", rd_data, m_rd);
    check("R10 changed", rd_data != prev, 1);

    // R11 write collides with capture
    trig_in = 0; tick(2); wr_en = 1; wr_data = 16'hABCD; tick(1); wr_en = 0;
    do_read();
    check("R11 capture wins", rd_data != 16'hABCD, 1);
    check("R11 value", rd_data, m_rd);

    // R9 width measurement clears counter
    mode = 2'd1; edge_sel = 2'd1; tick(20);
    for (int i = 0; i < 4; i++) begin
      trig_in = 1; tick(7 + i * 3); trig_in = 0; tick(5);
    end
    do_read(); check("R9 width value", rd_data, m_rd);

    // R12 wrap in compare use
    mode = 2'd2; cnt_en = 0; tick(2);
    do_write(16'hFFFE); tick(1);
    cnt_en = 1; out_en = 1; irq_seen = 0;
    tick(65545);
    check("R12 one match per wrap", irq_seen, 1);

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      cnt_en   = ($urandom_range(0, 15) != 0);
      if ($urandom_range(0, 63) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 63) == 0) cap_sel = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 63) == 0) edge_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) trig_in = ~trig_in;
      out_en  = 1'($urandom_range(0, 1));
      wr_en   = ($urandom_range(0, 20) == 0);
      wr_data = 16'($urandom_range(0, 30));
      rd_en   = 1'($urandom_range(0, 1));
      tick(1);
    end
    wr_en = 0; rd_en = 0; tick(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule